// File: doc/BRIEF.md
# Masked-Write GPIO Output Bank

This block owns the output side of a bank of eight general-purpose pins, numbered 8 to 15. It keeps three 16-bit registers: a latch register with the value each pin should drive, an enable register that allows each driver, and a mode register with a 2-bit field per pin. A host reaches them through a plain single-cycle register port. The block turns the stored state into a per-pin output value and output enable.

The latch and enable registers take masked writes. The upper byte of a write word selects which pins the write touches. The lower byte gives their new values. This lets separate software agents change their own pins without a read-modify-write sequence, so they cannot overwrite each other's pins. A pin drives only when its enable bit is set and its mode field selects plain output. After reset, every pin is an undriven input.

Top module: `gpio_out_bank`

## Requirements
- R1: A write to offset 0x72 sets latch bit k to `reg_wdata[k]` for each k in 0..7 where `reg_wdata[8+k]` is 1. Latch bit k controls pin 8+k.
- R2: During a write to 0x72 or 0x76, every latch or enable bit whose mask bit `reg_wdata[8+k]` is 0 keeps its previous value.
- R3: A write to offset 0x76 sets enable bit k to `reg_wdata[k]` for each k where `reg_wdata[8+k]` is 1.
- R4: Reading offset 0x72 or 0x76 returns the latch or enable bits in `reg_rdata[7:0]`, and zero in `reg_rdata[15:8]`, in the same cycle the address is presented.
- R5: A write to offset 0x82 replaces the whole mode register. Pin 8+k takes its mode from bits [2k+1:2k]. A read of 0x82 returns all 16 bits.
- R6: `pin_oe[k]` is 1 exactly when enable bit k is 1 and mode field k equals 2'b01. Modes 00, 10 and 11 hold it at 0.
- R7: `pin_out[k]` equals latch bit k while `pin_oe[k]` is 1, and is 0 otherwise.
- R8: A write to any other offset, or a cycle with `reg_wr` low, changes no register. A read of any other offset returns zero.
- R9: While `rst_n` is low, all latch, enable and mode bits are cleared, so every `pin_oe` and `pin_out` bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 16 | Write word |
| reg_rdata | output | 16 | Read word for `reg_addr`, combinational |
| pin_out | output | 8 | Output value for pins 8..15 |
| pin_oe | output | 8 | Output enable for pins 8..15 |

## Verification
A wrong state bit shows at the pins in the cycle after the write that caused it, as long as that pin is enabled and set to output mode. It also shows at once on a read of its register, because reads do not pass through any register. The sweep therefore walks every mask value against changing data for both masked registers. After each write it reads all three registers back and compares both pin vectors. A mask bit that leaks, or a mode decode that is off by one field, is caught within one write. All four mode codes are driven on every pin, with the enable bit both set and clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // Register offsets decoded by the bank
    localparam int OFS_LATCH  = 'h72;
    localparam int OFS_ENABLE = 'h76;
    localparam int OFS_MODE   = 'h82;

    typedef enum logic [1:0] {
        PMODE_INPUT  = 2'b00,
        PMODE_OUTPUT = 2'b01,
        PMODE_ALT_A  = 2'b10,
        PMODE_ALT_B  = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_masked_reg.sv
module gpio_masked_reg #(
    parameter int NPIN = 8,
    localparam int WW  = 2 * NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WW-1:0]   wdata,
    output logic [NPIN-1:0] val
);
    typedef struct packed {
        logic [NPIN-1:0] bits;
    } mreg_state_t;

    mreg_state_t st_d, st_q;
    logic [NPIN-1:0] wr_mask;
    logic [NPIN-1:0] wr_bits;

    assign wr_mask = wdata[WW-1:NPIN];
    assign wr_bits = wdata[NPIN-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bits = (st_q.bits & ~wr_mask) | (wr_bits & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.bits;

    // R1/R3: selected bits take the written value
    assert_masked_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (((val ^ $past(wdata[NPIN-1:0])) & $past(wdata[WW-1:NPIN])) == '0));
    // R2: unselected bits hold their value
    assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (((val ^ $past(val)) & ~$past(wdata[WW-1:NPIN])) == '0));
    // R8: no strobe, no change
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(val));
endmodule

// File: rtl/gpio_mode_reg.sv
module gpio_mode_reg #(
    parameter int NPIN = 8,
    localparam int MW  = 2 * NPIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [MW-1:0] wdata,
    output logic [MW-1:0] modes
);
    typedef struct packed {
        logic [MW-1:0] fields;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.fields = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign modes = st_q.fields;

    // R5: whole-word replacement
    assert_mode_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (modes == $past(wdata)));
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(modes));
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_bank_pkg::*;
(
    input  logic       latch,
    input  logic       enable,
    input  logic [1:0] mode,
    output logic       pad_out,
    output logic       pad_oe
);
    logic drive;

    always_comb begin
        drive   = enable && (pin_mode_e'(mode) == PMODE_OUTPUT);
        pad_oe  = drive;
        pad_out = drive & latch;
    end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 8,
    localparam int WW  = 2 * NPIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [WW-1:0]   reg_wdata,
    output logic [WW-1:0]   reg_rdata,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe
);
    localparam logic [AW-1:0] A_LATCH  = AW'(OFS_LATCH);
    localparam logic [AW-1:0] A_ENABLE = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_MODE   = AW'(OFS_MODE);

    logic            sel_latch, sel_enable, sel_mode;
    logic [NPIN-1:0] latch_q, enable_q;
    logic [WW-1:0]   mode_q;

    assign sel_latch  = (reg_addr == A_LATCH);
    assign sel_enable = (reg_addr == A_ENABLE);
    assign sel_mode   = (reg_addr == A_MODE);

    gpio_masked_reg #(.NPIN(NPIN)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_latch),
        .wdata(reg_wdata), .val(latch_q)
    );

    gpio_masked_reg #(.NPIN(NPIN)) u_enable (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_enable),
        .wdata(reg_wdata), .val(enable_q)
    );

    gpio_mode_reg #(.NPIN(NPIN)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && sel_mode),
        .wdata(reg_wdata), .modes(mode_q)
    );

    for (genvar k = 0; k < NPIN; k++) begin : g_pin
        gpio_pin_drive u_drv (
            .latch(latch_q[k]), .enable(enable_q[k]), .mode(mode_q[2*k +: 2]),
            .pad_out(pin_out[k]), .pad_oe(pin_oe[k])
        );

        assert_oe_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[k] |-> (enable_q[k] && mode_q[2*k +: 2] == 2'b01));
        assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_oe[k] |-> !pin_out[k]);
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_latch)       reg_rdata = {{NPIN{1'b0}}, latch_q};
        else if (sel_enable) reg_rdata = {{NPIN{1'b0}}, enable_q};
        else if (sel_mode)   reg_rdata = mode_q;
    end

    assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_latch || sel_enable) |-> (reg_rdata[WW-1:NPIN] == '0));
endmodule

// File: tb/tb_gpio_out_bank.sv
module tb_gpio_out_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [7:0]  pin_out, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0]  m_lat = 8'h0, m_en = 8'h0;
    logic [15:0] m_mode = 16'h0;

    always #5 clk = ~clk;

    gpio_out_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_oe();
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = m_en[k] && (m_mode[2*k +: 2] == 2'b01);
        return r;
    endfunction

    task automatic read_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    // Full observation: readback of all three registers plus pins
    task automatic check_all(input string tag);
        read_chk(8'h72, {8'h00, m_lat}, {tag, " R1 R4 latch"});
        read_chk(8'h76, {8'h00, m_en},  {tag, " R3 R4 enable"});
        read_chk(8'h82, m_mode,         {tag, " R5 mode"});
        check({tag, " R6 pin_oe"},  {8'h00, pin_oe},  {8'h00, exp_oe()});
        check({tag, " R7 pin_out"}, {8'h00, pin_out}, {8'h00, exp_oe() & m_lat});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h72) m_lat = (m_lat & ~d[15:8]) | (d[7:0] & d[15:8]);
        else if (a == 8'h76) m_en = (m_en & ~d[15:8]) | (d[7:0] & d[15:8]);
        else if (a == 8'h82) m_mode = d;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after release");

        // R1 R2: sweep every mask against varying data, pins in output mode
        do_write(8'h82, 16'h5555);
        do_write(8'h76, 16'hFFFF);
        check_all("R5 R3 setup");
        for (int m = 0; m < 256; m++) begin
            do_write(8'h72, {8'(m), 8'(m * 37) ^ 8'h5A});
            check_all("R1 R2 latch sweep");
        end

        // R3 R2: sweep enable masks with latch all ones
        do_write(8'h72, 16'hFFFF);
        for (int m = 0; m < 256; m++) begin
            do_write(8'h76, {8'(m), 8'(m * 91) ^ 8'hC3});
            check_all("R3 R2 enable sweep");
        end

        // R5 R6: every mode code on every pin, enable set then clear
        for (int e = 0; e < 2; e++) begin
            do_write(8'h76, e == 0 ? 16'hFFFF : 16'hFF00);
            for (int p = 0; p < 8; p++) begin
                for (int c = 0; c < 4; c++) begin
                    do_write(8'h82, (16'(c) << (2 * p)) | (16'h4000 >> (2 * p)));
                    check_all("R5 R6 mode decode");
                end
            end
        end

        // R8: stray offsets and idle strobe change nothing; reads give zero
        do_write(8'h82, 16'h9565);
        do_write(8'h76, 16'hFF0F);
        do_write(8'h72, 16'hFF3C);
        for (int a = 0; a < 256; a++) begin
            if (a != 'h72 && a != 'h76 && a != 'h82) begin
                do_write(8'(a), 16'hFFFF ^ 16'(a));
                read_chk(8'(a), 16'h0000, "R8 stray read");
            end
        end
        check_all("R8 after stray writes");
        @(negedge clk);
        reg_addr = 8'h72; reg_wdata = 16'hFF00; reg_wr = 1'b0;
        @(negedge clk);
        check_all("R8 idle strobe");

        // R9: reset mid-run clears everything
        rst_n = 1'b0;
        m_lat = '0; m_en = '0; m_mode = '0;
        #2;
        check_all("R9 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9 after mid reset");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule